// File: doc/BRIEF.md
# Byte/Word Data Port with Transmit and Receive FIFOs

This block sits between a 32-bit register interface and a serial shift engine. A single data register address carries data both ways. A write places data into a transmit FIFO, and the engine drains that FIFO one byte at a time. The engine fills a receive FIFO one byte at a time, and a read of the same address returns the data. A format bit selects packed mode. In packed mode every data access moves four bytes at once, with the least significant byte first in time. Otherwise every access moves one byte in bits 7:0.

Software watches a transmit-full flag and a receive-empty flag. Both flags take the current access size into account. A rejected access latches a sticky error bit. Three control bits are self-clearing and reset the engine, the receive FIFO and the transmit FIFO. Two further control bits enable level-based DMA request lines. A read-only configuration register reports each FIFO depth as an exponent code.

The depths are parameters: depth = 2^(code+1), and the code must be at least 1 so that a packed word fits.

Top module: `dataPort`

## Requirements
- R1: With packed mode off, a data write pushes only bits 7:0 of the written word. The engine receives the bytes in write order. A data read pops one byte and returns it in bits 7:0, with bits 31:8 zero.
- R2: Packed mode is format bit 7. With it set, a data write pushes four bytes, and the byte in bits 7:0 reaches the engine first. A data read pops four bytes, with the first byte received in bits 7:0.
- R3: Status bit 23 (transmit full) is 1 exactly when the free transmit entries are fewer than the access size (4 in packed mode, else 1). Status bit 14 (receive empty) is 1 exactly when the stored receive bytes are fewer than the access size.
- R4: A data write while transmit full is ignored and sets sticky status bit 24. A data read while receive empty pops nothing, returns 0 and sets sticky status bit 25.
- R5: The configuration register returns the receive depth code in bits 3:0 and the transmit depth code in bits 7:4.
- R6: Control bit 0 resets the engine, bit 1 resets the receive FIFO and bit 2 resets the transmit FIFO. Each bit reads 1 in the cycle after the write and 0 after that. A FIFO reset empties that FIFO and clears its sticky error bit. Bit 0 drives `engineRst` high for one cycle.
- R7: Control bit 3 enables `rxDmaReq` and bit 4 enables `txDmaReq`, and both bits read back. `txDmaReq` is high while at least half the transmit depth is free. `rxDmaReq` is high while at least half the receive depth is filled.
- R8: The format register holds bit 7 (packed mode) and bits 12:8 (unit length minus one). Its reset value is 0x0000_0700, and its other bits read 0.
- R9: After reset both FIFOs are empty, status reads 0x0000_4000 and both DMA requests are low.
- R10: Register select `regAddr` decodes as follows: 0 is format, 1 is control, 2 is status, 3 is data, 4 is configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on data reads) |
| regAddr | input | 3 | Register select |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of the read |
| txAvail | output | 1 | Transmit FIFO holds a byte |
| txPop | input | 1 | Engine takes `txByte` |
| txByte | output | 8 | Oldest transmit byte |
| rxSpace | output | 1 | Receive FIFO can accept a byte |
| rxPush | input | 1 | Engine delivers `rxByte` |
| rxByte | input | 8 | Received byte |
| engineRst | output | 1 | One-cycle engine reset |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
The bench builds the block with a transmit depth code of 2 (8 entries) and a receive depth code of 1 (4 entries). With these sizes two packed writes fill the transmit side, and one packed word fills the receive side. This makes the full and empty boundaries, the rejected packed write and the half-depth DMA thresholds reachable in a few accesses. The configuration readback also checks values that differ from the defaults.

// File: rtl/dport_pkg.sv
package dport_pkg;
  localparam int MERGE_BYTES = 4;
  localparam int NW = $clog2(MERGE_BYTES + 1);

  typedef enum logic [2:0] {
    SEL_FMT    = 3'd0,
    SEL_CTRL   = 3'd1,
    SEL_STATUS = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_CONFIG = 3'd4
  } regSel_t;

  typedef struct packed {
    logic [NW-1:0] txPushN;
    logic [NW-1:0] rxPopN;
    logic          txFlush;
    logic          rxFlush;
    logic          txOvf;
    logic          rxUdf;
  } dpStrobe_t;
endpackage

// File: rtl/byteFifo.sv
module byteFifo #(
  parameter int DEPTH_CODE = 2,
  parameter int LANES = 4,
  localparam int DEPTH = 1 << (DEPTH_CODE + 1),
  localparam int AW = DEPTH_CODE + 1,
  localparam int CW = AW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic [NW-1:0]         pushN,
  input  logic [LANES-1:0][7:0] din,
  input  logic [NW-1:0]         popN,
  output logic [LANES-1:0][7:0] dout,
  output logic [CW-1:0]         count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int i = 0; i < LANES; i++) begin
        if (NW'(i) < pushN) mem[wrPtr + AW'(i)] <= din[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushN);
      rdPtr <= rdPtr + AW'(popN);
      count <= count + CW'(pushN) - CW'(popN);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign dout[g] = mem[rdPtr + AW'(g)];
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (CW'(pushN) <= CW'(DEPTH) - count));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (CW'(popN) <= count));
endmodule

// File: rtl/dataPortCtl.sv
module dataPortCtl
  import dport_pkg::*;
#(
  parameter int TX_CODE = 3,
  parameter int RX_CODE = 3,
  localparam int TX_DEPTH = 1 << (TX_CODE + 1),
  localparam int TCW = TX_CODE + 2,
  localparam int RCW = RX_CODE + 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic           regRdEn,
  input  logic [2:0]     regAddr,
  input  logic [31:0]    regWdata,
  output logic [31:0]    regRdata,
  input  logic [TCW-1:0] txLevel,
  input  logic [RCW-1:0] rxLevel,
  input  logic           txErr,
  input  logic           rxErr,
  input  logic [31:0]    rxWord,
  output dpStrobe_t      strobe,
  output logic           txDmaEn,
  output logic           rxDmaEn,
  output logic           engineRst
);
  regSel_t       regSel;
  logic          merge;
  logic [4:0]    fmtLen;
  logic          engPend, rxPend, txPend;
  logic [NW-1:0] accBytes;
  logic [TCW-1:0] txFree;
  logic          txFullFlag, rxEmptyFlag;
  logic          dataWr, dataRd, ctrlWr;

  assign regSel      = regSel_t'(regAddr);
  assign accBytes    = merge ? NW'(MERGE_BYTES) : NW'(1);
  assign txFree      = TCW'(TX_DEPTH) - txLevel;
  assign txFullFlag  = txFree < TCW'(accBytes);
  assign rxEmptyFlag = rxLevel < RCW'(accBytes);
  assign dataWr      = regWrEn && (regSel == SEL_DATA);
  assign dataRd      = regRdEn && (regSel == SEL_DATA);
  assign ctrlWr      = regWrEn && (regSel == SEL_CTRL);

  always_comb begin
    strobe.txFlush = txPend;
    strobe.rxFlush = rxPend;
    strobe.txPushN = (dataWr && !txFullFlag && !txPend) ? accBytes : '0;
    strobe.rxPopN  = (dataRd && !rxEmptyFlag && !rxPend) ? accBytes : '0;
    strobe.txOvf   = dataWr && txFullFlag && !txPend;
    strobe.rxUdf   = dataRd && rxEmptyFlag && !rxPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      merge   <= 1'b0;
      fmtLen  <= 5'd7;
      engPend <= 1'b0;
      rxPend  <= 1'b0;
      txPend  <= 1'b0;
      rxDmaEn <= 1'b0;
      txDmaEn <= 1'b0;
    end else begin
      engPend <= 1'b0;
      rxPend  <= 1'b0;
      txPend  <= 1'b0;
      if (regWrEn) begin
        case (regSel)
          SEL_FMT: begin
            merge  <= regWdata[7];
            fmtLen <= regWdata[12:8];
          end
          SEL_CTRL: begin
            engPend <= regWdata[0];
            rxPend  <= regWdata[1];
            txPend  <= regWdata[2];
            rxDmaEn <= regWdata[3];
            txDmaEn <= regWdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  assign engineRst = engPend;

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_FMT: begin
        regRdata[7]    = merge;
        regRdata[12:8] = fmtLen;
      end
      SEL_CTRL: regRdata[4:0] = {txDmaEn, rxDmaEn, txPend, rxPend, engPend};
      SEL_STATUS: begin
        regRdata[14] = rxEmptyFlag;
        regRdata[23] = txFullFlag;
        regRdata[24] = txErr;
        regRdata[25] = rxErr;
      end
      SEL_DATA: begin
        if (!rxEmptyFlag && !rxPend)
          regRdata = merge ? rxWord : {24'b0, rxWord[7:0]};
      end
      SEL_CONFIG: regRdata[7:0] = {4'(TX_CODE), 4'(RX_CODE)};
      default: ;
    endcase
  end

  // R6: a reset request lasts one cycle unless it is written again
  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((engPend || rxPend || txPend) && !ctrlWr) |=> !(engPend || rxPend || txPend));
endmodule

// File: rtl/dataPortPath.sv
module dataPortPath
  import dport_pkg::*;
#(
  parameter int TX_CODE = 3,
  parameter int RX_CODE = 3,
  localparam int TX_DEPTH = 1 << (TX_CODE + 1),
  localparam int RX_DEPTH = 1 << (RX_CODE + 1),
  localparam int TCW = TX_CODE + 2,
  localparam int RCW = RX_CODE + 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic [31:0]    regWdata,
  input  logic           txDmaEn,
  input  logic           rxDmaEn,
  output logic [TCW-1:0] txLevel,
  output logic [RCW-1:0] rxLevel,
  output logic           txErr,
  output logic           rxErr,
  output logic [31:0]    rxWord,
  output logic           txAvail,
  input  logic           txPop,
  output logic [7:0]     txByte,
  output logic           rxSpace,
  input  logic           rxPush,
  input  logic [7:0]     rxByte,
  output logic           txDmaReq,
  output logic           rxDmaReq
);
  logic [MERGE_BYTES-1:0][7:0] txDout, rxDout, rxDin;
  logic [NW-1:0] txPopN, rxPushN;

  assign txAvail = txLevel != '0;
  assign rxSpace = rxLevel != RCW'(RX_DEPTH);
  assign txPopN  = (txPop && txAvail) ? NW'(1) : '0;
  assign rxPushN = (rxPush && rxSpace) ? NW'(1) : '0;
  assign rxDin   = {MERGE_BYTES{rxByte}};
  assign txByte  = txDout[0];
  assign rxWord  = rxDout;

  byteFifo #(.DEPTH_CODE(TX_CODE), .LANES(MERGE_BYTES)) txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush),
    .pushN(strobe.txPushN), .din(regWdata), .popN(txPopN),
    .dout(txDout), .count(txLevel));

  byteFifo #(.DEPTH_CODE(RX_CODE), .LANES(MERGE_BYTES)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush),
    .pushN(rxPushN), .din(rxDin), .popN(strobe.rxPopN),
    .dout(rxDout), .count(rxLevel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txErr <= 1'b0;
      rxErr <= 1'b0;
    end else begin
      if (strobe.txFlush) txErr <= 1'b0;
      else if (strobe.txOvf) txErr <= 1'b1;
      if (strobe.rxFlush) rxErr <= 1'b0;
      else if (strobe.rxUdf) rxErr <= 1'b1;
    end
  end

  assign txDmaReq = txDmaEn && ((TCW'(TX_DEPTH) - txLevel) >= TCW'(TX_DEPTH / 2));
  assign rxDmaReq = rxDmaEn && (rxLevel >= RCW'(RX_DEPTH / 2));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txFlush && strobe.rxFlush) |=> (txLevel == '0 && rxLevel == '0));
  assert_sticky_tx_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !strobe.txFlush) |=> txErr);
  assert_sticky_rx_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxErr && !strobe.rxFlush) |=> rxErr);
endmodule

// File: rtl/dataPort.sv
module dataPort
  import dport_pkg::*;
#(
  parameter int TX_DEPTH_CODE = 3,
  parameter int RX_DEPTH_CODE = 3,
  localparam int TCW = TX_DEPTH_CODE + 2,
  localparam int RCW = RX_DEPTH_CODE + 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        txAvail,
  input  logic        txPop,
  output logic [7:0]  txByte,
  output logic        rxSpace,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  output logic        engineRst,
  output logic        txDmaReq,
  output logic        rxDmaReq
);
  dpStrobe_t      strobe;
  logic [TCW-1:0] txLevel;
  logic [RCW-1:0] rxLevel;
  logic           txErr, rxErr, txDmaEn, rxDmaEn;
  logic [31:0]    rxWord;

  dataPortCtl #(.TX_CODE(TX_DEPTH_CODE), .RX_CODE(RX_DEPTH_CODE)) ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txLevel(txLevel), .rxLevel(rxLevel), .txErr(txErr), .rxErr(rxErr),
    .rxWord(rxWord), .strobe(strobe), .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .engineRst(engineRst));

  dataPortPath #(.TX_CODE(TX_DEPTH_CODE), .RX_CODE(RX_DEPTH_CODE)) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn), .txLevel(txLevel), .rxLevel(rxLevel),
    .txErr(txErr), .rxErr(rxErr), .rxWord(rxWord), .txAvail(txAvail),
    .txPop(txPop), .txByte(txByte), .rxSpace(rxSpace), .rxPush(rxPush),
    .rxByte(rxByte), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq));
endmodule

// File: tb/tb_dataPort.sv
module tb_dataPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txAvail, txPop = 1'b0;
  logic [7:0]  txByte;
  logic        rxSpace, rxPush = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        engineRst, txDmaReq, rxDmaReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_FMT = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2,
                         A_DATA = 3'd3, A_CFG = 3'd4;

  always #4 clk = ~clk;

  dataPort #(.TX_DEPTH_CODE(2), .RX_DEPTH_CODE(1)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txAvail(txAvail), .txPop(txPop), .txByte(txByte), .rxSpace(rxSpace),
    .rxPush(rxPush), .rxByte(rxByte), .engineRst(engineRst),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic engPop(output logic [7:0] b);
    @(negedge clk);
    b = txByte;
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1'b1; rxByte = b;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic clearAll();
    busWrite(A_CTRL, 32'h6);
    busWrite(A_FMT, 32'h700);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(A_STAT, d);  chk("R9 status after reset", d, 32'h0000_4000);
    chk("R9 dma requests low", {30'b0, txDmaReq, rxDmaReq}, 32'h0);
    chk("R9 tx fifo empty", {31'b0, txAvail}, 32'h0);
    busRead(A_CFG, d);   chk("R5 depth codes", d, 32'h0000_0021);
    busRead(A_FMT, d);   chk("R8 format reset value", d, 32'h0000_0700);
  endtask

  task automatic testByteMode();
    logic [31:0] d; logic [7:0] b;
    busWrite(A_DATA, 32'hAABBCC11);
    busWrite(A_DATA, 32'h00000022);
    engPop(b); chk("R1 first byte", {24'b0, b}, 32'h11);
    engPop(b); chk("R1 second byte", {24'b0, b}, 32'h22);
    #1 chk("R1 tx drained", {31'b0, txAvail}, 32'h0);
    engPush(8'h5A);
    busRead(A_DATA, d); chk("R1 byte read", d, 32'h0000_005A);
    busRead(A_STAT, d); chk("R1 rx empty again", d, 32'h0000_4000);
  endtask

  task automatic testMerge();
    logic [31:0] d; logic [7:0] b;
    busWrite(A_FMT, 32'h780);
    busWrite(A_DATA, 32'h44332211);
    for (int i = 0; i < 4; i++) begin
      engPop(b);
      chk("R2 packed byte order", {24'b0, b}, 32'h11 * (i + 1));
    end
    engPush(8'hA1); engPush(8'hA2); engPush(8'hA3);
    busRead(A_STAT, d); chk("R3 three bytes still empty in packed mode", d, 32'h0000_4000);
    engPush(8'hA4);
    busRead(A_STAT, d); chk("R3 four bytes not empty", d, 32'h0);
    busRead(A_DATA, d); chk("R2 packed read", d, 32'hA4A3A2A1);
    clearAll();
  endtask

  task automatic testFullEmpty();
    logic [31:0] d; logic [7:0] b;
    busWrite(A_FMT, 32'h780);
    busWrite(A_DATA, 32'h04030201);
    busRead(A_STAT, d); chk("R3 four free not full", d, 32'h0000_4000);
    busWrite(A_DATA, 32'h08070605);
    busRead(A_STAT, d); chk("R3 tx full", d, 32'h0080_4000);
    busWrite(A_DATA, 32'hDEADBEEF);
    busRead(A_STAT, d); chk("R4 overflow sticky", d, 32'h0180_4000);
    busRead(A_DATA, d); chk("R4 empty read returns zero", d, 32'h0);
    busRead(A_STAT, d); chk("R4 underflow sticky", d, 32'h0380_4000);
    for (int i = 1; i <= 8; i++) begin
      engPop(b);
      chk("R4 contents kept after rejected write", {24'b0, b}, i);
    end
    #1 chk("R4 rejected word not stored", {31'b0, txAvail}, 32'h0);
    busWrite(A_FMT, 32'h700);
    engPush(8'h33);
    busRead(A_STAT, d); chk("R3 byte mode one byte not empty", d, 32'h0300_0000);
    clearAll();
  endtask

  task automatic testResetBits();
    logic [31:0] d;
    busWrite(A_DATA, 32'h77);
    busWrite(A_DATA, 32'h78);
    busRead(A_DATA, d);
    busRead(A_DATA, d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_CTRL; regWdata = 32'h7;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 chk("R6 bits read one after write", regRdata, 32'h7);
    chk("R6 engine reset high", {31'b0, engineRst}, 32'h1);
    @(negedge clk);
    #1 chk("R6 bits self-cleared", regRdata, 32'h0);
    chk("R6 engine reset one cycle", {31'b0, engineRst}, 32'h0);
    chk("R6 tx fifo emptied", {31'b0, txAvail}, 32'h0);
    busRead(A_STAT, d); chk("R6 sticky errors cleared", d, 32'h0000_4000);
  endtask

  task automatic testDma();
    logic [31:0] d;
    busWrite(A_CTRL, 32'h18);
    busRead(A_CTRL, d); chk("R7 enables read back", d, 32'h18);
    chk("R7 tx request with empty fifo", {31'b0, txDmaReq}, 32'h1);
    chk("R7 rx request low when empty", {31'b0, rxDmaReq}, 32'h0);
    for (int i = 0; i < 4; i++) busWrite(A_DATA, i);
    #1 chk("R7 tx request at half free", {31'b0, txDmaReq}, 32'h1);
    busWrite(A_DATA, 32'h9);
    #1 chk("R7 tx request drops below half free", {31'b0, txDmaReq}, 32'h0);
    engPush(8'h01);
    #1 chk("R7 rx request below half", {31'b0, rxDmaReq}, 32'h0);
    engPush(8'h02);
    #1 chk("R7 rx request at half", {31'b0, rxDmaReq}, 32'h1);
    busWrite(A_CTRL, 32'h0);
    #1 chk("R7 requests off when disabled", {30'b0, txDmaReq, rxDmaReq}, 32'h0);
    clearAll();
  endtask

  task automatic testFormatAndDecode();
    logic [31:0] d;
    busWrite(A_FMT, 32'hFFFF_FFFF);
    busRead(A_FMT, d); chk("R8 format only defined bits", d, 32'h0000_1F80);
    busRead(A_CFG, d); chk("R10 config select unaffected", d, 32'h0000_0021);
    busWrite(A_CFG, 32'hFFFF_FFFF);
    busRead(A_CFG, d); chk("R5 config read-only", d, 32'h0000_0021);
    busWrite(A_FMT, 32'h700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testByteMode();
    testMerge();
    testFullEmpty();
    testResetBits();
    testDma();
    testFormatAndDecode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule